// File: doc/BRIEF.md
# Store Write Classifier and Router

This block accepts one processor store request at a time and decides where it goes. It first turns the request's acquire, release and conditional flags into a three-bit write kind. It then checks natural alignment for the ordered and conditional forms. After that it consults an external protection verdict, if protection checking is enabled. Last, it consults external region-decode flags and steers the request to a memory-mapped I/O port, to a physical memory port, or to a fault port.

The decision is combinational and is captured when the request is accepted on a valid/ready handshake. The registered result is presented on exactly one output port in the next cycle. It is held there until that port's ready is seen. A small state machine has four states. S_IDLE accepts a request. S_MMIO, S_MEM and S_FAULT each hold one result. From S_IDLE, an accepted request moves the machine to the state its route selects. From any holding state, the matching ready returns it to S_IDLE.

Top module: `store_route_unit`

## Requirements
- R1: The write kind on the memory port encodes the flags {aq,rl,con} as: 000 gives 0 (plain), 010 gives 1 (release), 001 gives 2 (conditional), 011 gives 3 (conditional release), 110 gives 4 (strong release), 111 gives 5 (conditional strong release).
- R2: The flag combinations 100 and 101 produce a fault response with fault_unsup=1 and fault_code=0, and no write is issued.
- R3: If rl or con is set and the address is not naturally aligned, the result is a fault with code 6 and fault_unsup=0. The size code 0..3 means 1, 2, 4 or 8 bytes, and natural alignment means the low size-code address bits are zero. Plain and aq-only stores skip this check.
- R4: The checks apply in this fixed order: misalignment, then unsupported flags, then protection, then region decode. The first one that fails decides the result.
- R5: With pchk_en=1 and pchk_fail=1, the fault carries pchk_code and fault_unsup=0, whatever the region flags say.
- R6: With pchk_en=0, pchk_fail has no effect and the request goes to region decode.
- R7: Region decode picks MMIO when rgn_mmio=1 (even if rgn_mem=1). Otherwise it picks memory when rgn_mem=1. Otherwise it raises a fault with code 7.
- R8: The memory port carries the address, size, data, write kind and metadata. The metadata is req_meta when req_meta_en=1 and DEFAULT_META (0xA) otherwise. The MMIO port carries only the address, size and data.
- R9: req_ready is high only in S_IDLE. Each accepted request raises exactly one of mmio_valid, mem_valid or fault_valid in the cycle after acceptance. That valid and its payload stay stable until the matching ready.
- R10: After reset, req_ready=1 and all three output valids are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_addr | input | ADDR_W | Store address |
| req_size | input | 2 | Size code: bytes = 1 << code |
| req_data | input | DATA_W | Store data |
| req_meta | input | META_W | Explicit metadata |
| req_meta_en | input | 1 | Use req_meta instead of the default |
| req_aq | input | 1 | Acquire flag |
| req_rl | input | 1 | Release flag |
| req_con | input | 1 | Conditional flag |
| pchk_en | input | 1 | Protection checking enabled |
| pchk_fail | input | 1 | Protection check failed |
| pchk_code | input | 5 | Fault code supplied by the protection check |
| rgn_mmio | input | 1 | Address lies in the writable MMIO range |
| rgn_mem | input | 1 | Address lies in physical memory |
| mmio_valid | output | 1 | MMIO write present |
| mmio_ready | input | 1 | MMIO write consumed |
| mmio_addr | output | ADDR_W | MMIO address |
| mmio_size | output | 2 | MMIO size code |
| mmio_data | output | DATA_W | MMIO data |
| mem_valid | output | 1 | Memory write present |
| mem_ready | input | 1 | Memory write consumed |
| mem_addr | output | ADDR_W | Memory address |
| mem_size | output | 2 | Memory size code |
| mem_data | output | DATA_W | Memory data |
| mem_meta | output | META_W | Memory metadata |
| mem_kind | output | 3 | Write kind |
| fault_valid | output | 1 | Fault response present |
| fault_ready | input | 1 | Fault response consumed |
| fault_code | output | 5 | Exception code |
| fault_unsup | output | 1 | Unsupported flag combination |

## Verification
The assertions assume that the request inputs are only meaningful while req_valid is high. They also assume that the protection and region flags arrive in the same cycle as the request they describe. The bench drives every request input together at a falling edge and holds it through exactly one accepting rising edge. It drops req_valid before the next edge, so no stale flags are paired with a later request. The bench raises the output readies only after sampling the held result. This lets the hold-until-ready properties be tested against real back-pressure.

// File: rtl/store_route_pkg.sv
package store_route_pkg;

    localparam int CODE_W = 5;
    localparam logic [CODE_W-1:0] CODE_MISALIGN = 5'd6;
    localparam logic [CODE_W-1:0] CODE_ACCESS   = 5'd7;
    localparam logic [CODE_W-1:0] CODE_NONE     = 5'd0;

    typedef enum logic [2:0] {
        WK_PLAIN           = 3'd0,
        WK_REL             = 3'd1,
        WK_COND            = 3'd2,
        WK_COND_REL        = 3'd3,
        WK_STRONG_REL      = 3'd4,
        WK_COND_STRONG_REL = 3'd5
    } wkind_e;

    typedef enum logic [1:0] {
        RT_MMIO  = 2'd0,
        RT_MEM   = 2'd1,
        RT_FAULT = 2'd2
    } route_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_MMIO  = 2'd1,
        S_MEM   = 2'd2,
        S_FAULT = 2'd3
    } st_e;

endpackage

// File: rtl/wkind_classifier.sv
module wkind_classifier
    import store_route_pkg::*;
(
    input  logic   aq,
    input  logic   rl,
    input  logic   con,
    output wkind_e kind,
    output logic   unsup
);
    always_comb begin
        kind  = WK_PLAIN;
        unsup = 1'b0;
        unique case ({aq, rl, con})
            3'b000: kind = WK_PLAIN;
            3'b010: kind = WK_REL;
            3'b001: kind = WK_COND;
            3'b011: kind = WK_COND_REL;
            3'b110: kind = WK_STRONG_REL;
            3'b111: kind = WK_COND_STRONG_REL;
            default: unsup = 1'b1;   // 100 and 101
        endcase
    end
endmodule

// File: rtl/align_checker.sv
module align_checker #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output logic              misaligned
);
    logic [2:0] low_mask;

    always_comb begin
        unique case (size)
            2'd0: low_mask = 3'b000;
            2'd1: low_mask = 3'b001;
            2'd2: low_mask = 3'b011;
            default: low_mask = 3'b111;
        endcase
        misaligned = |(addr[2:0] & low_mask);
    end
endmodule

// File: rtl/route_decider.sv
module route_decider
    import store_route_pkg::*;
(
    input  logic              ordered,
    input  logic              misaligned,
    input  logic              unsup,
    input  logic              pchk_en,
    input  logic              pchk_fail,
    input  logic [CODE_W-1:0] pchk_code,
    input  logic              rgn_mmio,
    input  logic              rgn_mem,
    output route_e            route,
    output logic [CODE_W-1:0] code,
    output logic              unsup_out
);
    // Fixed precedence: alignment, flag support, protection, region.
    always_comb begin
        route     = RT_FAULT;
        code      = CODE_NONE;
        unsup_out = 1'b0;
        if (ordered && misaligned) begin
            code = CODE_MISALIGN;
        end else if (unsup) begin
            unsup_out = 1'b1;
        end else if (pchk_en && pchk_fail) begin
            code = pchk_code;
        end else if (rgn_mmio) begin
            route = RT_MMIO;
        end else if (rgn_mem) begin
            route = RT_MEM;
        end else begin
            code = CODE_ACCESS;
        end
    end
endmodule

// File: rtl/store_route_unit.sv
module store_route_unit
    import store_route_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64,
    parameter int META_W = 4,
    parameter logic [META_W-1:0] DEFAULT_META = META_W'(10)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [DATA_W-1:0] req_data,
    input  logic [META_W-1:0] req_meta,
    input  logic              req_meta_en,
    input  logic              req_aq,
    input  logic              req_rl,
    input  logic              req_con,
    input  logic              pchk_en,
    input  logic              pchk_fail,
    input  logic [CODE_W-1:0] pchk_code,
    input  logic              rgn_mmio,
    input  logic              rgn_mem,
    output logic              mmio_valid,
    input  logic              mmio_ready,
    output logic [ADDR_W-1:0] mmio_addr,
    output logic [1:0]        mmio_size,
    output logic [DATA_W-1:0] mmio_data,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_size,
    output logic [DATA_W-1:0] mem_data,
    output logic [META_W-1:0] mem_meta,
    output logic [2:0]        mem_kind,
    output logic              fault_valid,
    input  logic              fault_ready,
    output logic [CODE_W-1:0] fault_code,
    output logic              fault_unsup
);
    wkind_e            kind_c;
    logic              unsup_c;
    logic              misal_c;
    route_e            route_c;
    logic [CODE_W-1:0] code_c;
    logic              unsup_f;

    wkind_classifier u_cls (
        .aq(req_aq), .rl(req_rl), .con(req_con),
        .kind(kind_c), .unsup(unsup_c)
    );

    align_checker #(.ADDR_W(ADDR_W)) u_aln (
        .addr(req_addr), .size(req_size), .misaligned(misal_c)
    );

    route_decider u_rte (
        .ordered(req_rl | req_con), .misaligned(misal_c), .unsup(unsup_c),
        .pchk_en(pchk_en), .pchk_fail(pchk_fail), .pchk_code(pchk_code),
        .rgn_mmio(rgn_mmio), .rgn_mem(rgn_mem),
        .route(route_c), .code(code_c), .unsup_out(unsup_f)
    );

    st_e               state, state_nx;
    logic              accept;
    logic [ADDR_W-1:0] q_addr;
    logic [1:0]        q_size;
    logic [DATA_W-1:0] q_data;
    logic [META_W-1:0] q_meta;
    wkind_e            q_kind;
    logic [CODE_W-1:0] q_code;
    logic              q_unsup;

    assign accept = req_valid && (state == S_IDLE);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: if (req_valid) begin
                unique case (route_c)
                    RT_MMIO: state_nx = S_MMIO;
                    RT_MEM:  state_nx = S_MEM;
                    default: state_nx = S_FAULT;
                endcase
            end
            S_MMIO:  if (mmio_ready)  state_nx = S_IDLE;
            S_MEM:   if (mem_ready)   state_nx = S_IDLE;
            S_FAULT: if (fault_ready) state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // Payload capture on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_addr  <= '0;
            q_size  <= '0;
            q_data  <= '0;
            q_meta  <= '0;
            q_kind  <= WK_PLAIN;
            q_code  <= '0;
            q_unsup <= 1'b0;
        end else if (accept) begin
            q_addr  <= req_addr;
            q_size  <= req_size;
            q_data  <= req_data;
            q_meta  <= req_meta_en ? req_meta : DEFAULT_META;
            q_kind  <= kind_c;
            q_code  <= code_c;
            q_unsup <= unsup_f;
        end
    end

    // Outputs
    always_comb begin
        req_ready   = (state == S_IDLE);
        mmio_valid  = (state == S_MMIO);
        mem_valid   = (state == S_MEM);
        fault_valid = (state == S_FAULT);
        mmio_addr   = q_addr;
        mmio_size   = q_size;
        mmio_data   = q_data;
        mem_addr    = q_addr;
        mem_size    = q_size;
        mem_data    = q_data;
        mem_meta    = q_meta;
        mem_kind    = q_kind;
        fault_code  = q_code;
        fault_unsup = q_unsup;
    end
endmodule

// File: rtl/store_route_checker.sv
module store_route_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic [1:0]        req_size,
    input logic              req_aq,
    input logic              req_rl,
    input logic              req_con,
    input logic              mmio_valid,
    input logic              mmio_ready,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [2:0]        mem_kind,
    input logic              fault_valid,
    input logic              fault_ready,
    input logic [4:0]        fault_code,
    input logic              fault_unsup
);
    logic odd_addr;
    assign odd_addr = req_addr[0] && (req_size != 2'd0);

    AST_ONE_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mmio_valid, mem_valid, fault_valid}));                             // R9
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (mmio_valid || mem_valid || fault_valid) |-> !req_ready);                  // R9
    AST_ACCEPT_ROUTES: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (mmio_valid || mem_valid || fault_valid));    // R9
    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)));           // R9
    AST_MMIO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mmio_valid && !mmio_ready) |=> mmio_valid);                               // R9
    AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_valid && !fault_ready) |=> (fault_valid && $stable(fault_code)));   // R9
    AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (mem_kind <= 3'd5));                                         // R1
    AST_AQ_ONLY_UNSUP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_aq && !req_rl && !req_con)
        |=> (fault_valid && fault_unsup));                                         // R2
    AST_ODD_MISALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_rl || req_con) && odd_addr)
        |=> (fault_valid && fault_code == 5'd6 && !fault_unsup));                  // R3
endmodule

bind store_route_unit store_route_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .req_aq(req_aq), .req_rl(req_rl),
    .req_con(req_con), .mmio_valid(mmio_valid), .mmio_ready(mmio_ready),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_kind(mem_kind), .fault_valid(fault_valid), .fault_ready(fault_ready),
    .fault_code(fault_code), .fault_unsup(fault_unsup)
);

// File: tb/store_route_unit_test.sv
`timescale 1ns/1ps
module store_route_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [63:0] req_data = '0;
    logic [3:0]  req_meta = '0;
    logic        req_meta_en = 1'b0;
    logic        req_aq = 1'b0, req_rl = 1'b0, req_con = 1'b0;
    logic        pchk_en = 1'b0, pchk_fail = 1'b0;
    logic [4:0]  pchk_code = 5'd13;
    logic        rgn_mmio = 1'b0, rgn_mem = 1'b0;
    logic        mmio_valid, mmio_ready = 1'b0;
    logic [31:0] mmio_addr;
    logic [1:0]  mmio_size;
    logic [63:0] mmio_data;
    logic        mem_valid, mem_ready = 1'b0;
    logic [31:0] mem_addr;
    logic [1:0]  mem_size;
    logic [63:0] mem_data;
    logic [3:0]  mem_meta;
    logic [2:0]  mem_kind;
    logic        fault_valid, fault_ready = 1'b0;
    logic [4:0]  fault_code;
    logic        fault_unsup;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    store_route_unit uut (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            errors++;
            $display("FAIL R9 watchdog: actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // route: 0 mmio, 1 mem, 2 fault
    typedef struct packed {
        logic [31:0] addr;
        logic [1:0]  size;
        logic aq, rl, con, pen, pfail, rmmio, rmem;
        logic [1:0]  route;
        logic [4:0]  code;
        logic [2:0]  kind;
        logic        unsup;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VT [NV] = '{
        '{32'h1000, 2'd3, 1'b0,1'b0,1'b0, 1'b0,1'b0, 1'b0,1'b1, 2'd1, 5'd0, 3'd0, 1'b0}, // R1 000
        '{32'h1000, 2'd3, 1'b0,1'b1,1'b0, 1'b0,1'b0, 1'b0,1'b1, 2'd1, 5'd0, 3'd1, 1'b0}, // R1 010
        '{32'h1000, 2'd3, 1'b0,1'b0,1'b1, 1'b0,1'b0, 1'b0,1'b1, 2'd1, 5'd0, 3'd2, 1'b0}, // R1 001
        '{32'h1000, 2'd3, 1'b0,1'b1,1'b1, 1'b0,1'b0, 1'b0,1'b1, 2'd1, 5'd0, 3'd3, 1'b0}, // R1 011
        '{32'h1000, 2'd3, 1'b1,1'b1,1'b0, 1'b0,1'b0, 1'b0,1'b1, 2'd1, 5'd0, 3'd4, 1'b0}, // R1 110
        '{32'h1000, 2'd3, 1'b1,1'b1,1'b1, 1'b0,1'b0, 1'b0,1'b1, 2'd1, 5'd0, 3'd5, 1'b0}, // R1 111
        '{32'h1000, 2'd3, 1'b1,1'b0,1'b0, 1'b0,1'b0, 1'b0,1'b1, 2'd2, 5'd0, 3'd0, 1'b1}, // R2 100
        '{32'h1000, 2'd3, 1'b1,1'b0,1'b1, 1'b0,1'b0, 1'b0,1'b1, 2'd2, 5'd0, 3'd0, 1'b1}, // R2 101
        '{32'h1002, 2'd2, 1'b1,1'b0,1'b1, 1'b0,1'b0, 1'b0,1'b1, 2'd2, 5'd6, 3'd0, 1'b0}, // R4 101 odd
        '{32'h1002, 2'd2, 1'b1,1'b0,1'b0, 1'b0,1'b0, 1'b0,1'b1, 2'd2, 5'd0, 3'd0, 1'b1}, // R2 100 odd
        '{32'h1003, 2'd3, 1'b0,1'b0,1'b0, 1'b0,1'b0, 1'b0,1'b1, 2'd1, 5'd0, 3'd0, 1'b0}, // R3 plain odd
        '{32'h1001, 2'd1, 1'b0,1'b1,1'b0, 1'b0,1'b0, 1'b0,1'b1, 2'd2, 5'd6, 3'd0, 1'b0}, // R3 half odd
        '{32'h1003, 2'd0, 1'b0,1'b0,1'b1, 1'b0,1'b0, 1'b0,1'b1, 2'd1, 5'd0, 3'd2, 1'b0}, // R3 byte
        '{32'h1000, 2'd3, 1'b0,1'b0,1'b0, 1'b1,1'b1, 1'b0,1'b1, 2'd2, 5'd13,3'd0, 1'b0}, // R5
        '{32'h1000, 2'd3, 1'b0,1'b0,1'b0, 1'b0,1'b1, 1'b0,1'b1, 2'd1, 5'd0, 3'd0, 1'b0}, // R6
        '{32'h2000, 2'd2, 1'b0,1'b0,1'b0, 1'b1,1'b0, 1'b1,1'b1, 2'd0, 5'd0, 3'd0, 1'b0}, // R7 mmio first
        '{32'h3000, 2'd2, 1'b0,1'b0,1'b0, 1'b0,1'b0, 1'b0,1'b0, 2'd2, 5'd7, 3'd0, 1'b0}, // R7 no region
        '{32'h1004, 2'd3, 1'b0,1'b1,1'b0, 1'b1,1'b1, 1'b0,1'b1, 2'd2, 5'd6, 3'd0, 1'b0}, // R4 align>prot
        '{32'h1000, 2'd3, 1'b1,1'b0,1'b0, 1'b1,1'b1, 1'b0,1'b1, 2'd2, 5'd0, 3'd0, 1'b1}, // R4 unsup>prot
        '{32'h2004, 2'd1, 1'b0,1'b1,1'b0, 1'b0,1'b0, 1'b1,1'b0, 2'd0, 5'd0, 3'd0, 1'b0}  // R7 mmio only
    };

    task automatic send(input vec_t v, input logic [63:0] d, input logic men, input logic [3:0] m);
        @(negedge clk);
        req_addr = v.addr; req_size = v.size; req_data = d;
        req_meta = m; req_meta_en = men;
        req_aq = v.aq; req_rl = v.rl; req_con = v.con;
        pchk_en = v.pen; pchk_fail = v.pfail;
        rgn_mmio = v.rmmio; rgn_mem = v.rmem;
        req_valid = 1'b1;
        @(posedge clk);
        #1 req_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic drain;
        mmio_ready = 1'b1; mem_ready = 1'b1; fault_ready = 1'b1;
        @(posedge clk);
        #1;
        mmio_ready = 1'b0; mem_ready = 1'b0; fault_ready = 1'b0;
        @(negedge clk);
        chk(req_ready && !mmio_valid && !mem_valid && !fault_valid, "R9", "idle after ready",
            {mmio_valid, mem_valid, fault_valid}, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(req_ready && !mmio_valid && !mem_valid && !fault_valid, "R10", "reset state",
            {req_ready, mmio_valid, mem_valid, fault_valid}, 4'b1000);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            vec_t v = VT[i];
            logic [63:0] d = 64'h0123_4567_89AB_0000 | 64'(i);
            logic [1:0] got;
            string tg;
            if (v.route == 2'd1) tg = "R1";
            else if (v.route == 2'd0) tg = "R7";
            else if (v.unsup) tg = "R2";
            else if (v.code == 5'd6) tg = "R3";
            else if (v.code == 5'd13) tg = "R5";
            else tg = "R7";
            if (i == 8 || i == 17 || i == 18) tg = "R4";
            if (i == 14) tg = "R6";
            send(v, d, 1'b1, 4'h3);
            got = mmio_valid ? 2'd0 : mem_valid ? 2'd1 : fault_valid ? 2'd2 : 2'd3;
            chk(got == v.route && $countones({mmio_valid, mem_valid, fault_valid}) == 1,
                tg, $sformatf("route vec %0d", i), got, v.route);
            if (v.route == 2'd1) begin
                chk(mem_kind == v.kind, tg, "kind", mem_kind, v.kind);
                chk(mem_addr == v.addr && mem_data == d && mem_size == v.size && mem_meta == 4'h3,
                    "R8", "mem payload", mem_data, d);
            end else if (v.route == 2'd0) begin
                chk(mmio_addr == v.addr && mmio_data == d && mmio_size == v.size,
                    "R8", "mmio payload", mmio_data, d);
            end else begin
                chk(fault_code == v.code && fault_unsup == v.unsup, tg, "fault",
                    {fault_unsup, fault_code}, {v.unsup, v.code});
            end
            drain();
        end

        // R8: default metadata when none supplied
        send(VT[0], 64'hAA, 1'b0, 4'h3);
        chk(mem_valid && mem_meta == 4'hA, "R8", "default meta", mem_meta, 4'hA);
        drain();

        // R9: back-pressure holds the result and blocks new requests
        send(VT[1], 64'h55, 1'b1, 4'h5);
        req_valid = 1'b1; req_aq = 1'b1; req_rl = 1'b0; req_con = 1'b0;
        repeat (3) @(negedge clk);
        chk(mem_valid && !req_ready && mem_data == 64'h55 && mem_kind == 3'd1 && mem_meta == 4'h5,
            "R9", "held under back-pressure", mem_data, 64'h55);
        req_valid = 1'b0;
        drain();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule